// File: doc/BRIEF.md
# JTAG-Accessed Job Register Bank with Result Queue

This block is the device end of a register file reached over a JTAG user data register. A TAP controller, which lives outside the block, selects the user instruction and drives one-cycle capture, shift and update strobes in the TCK domain. The bank gathers the serial bits, decodes each frame when the update strobe arrives, checks its odd parity, and then either commits a 32-bit write or prepares a 32-bit word. The host shifts that word out on its next data scan.

Eleven job words sit at addresses 1 to 11. A write to the last of them hands the whole job to the core clock domain and raises a one-cycle start pulse there. Address 0xD holds a clock setting, which is also carried into the core domain. A read of address 0xE takes the oldest entry from a result queue. The core fills that queue in its own clock domain, and a read of an empty queue returns all ones. Frames of an illegal length, or with a bad flag or bad parity, are dropped and counted.

Top module: `jtag_regbank`

## Requirements
- R1: A write frame is 38 bits shifted in LSB first: bits 0-31 are data, bits 32-35 the address, bit 36 a write flag equal to 1, and bit 37 parity. When it is accepted, the addressed register takes the data.
- R2: A read request is 6 bits: bits 0-3 the address, bit 4 a flag equal to 0, bit 5 parity. The next capture loads the requested 32-bit value, and `tdo` presents it LSB first, one bit per shift cycle, starting directly after capture.
- R3: A frame is accepted only if the ones in all of its bits, parity included, add up to an odd number. A frame that fails this changes no register and raises `err_count` by exactly one.
- R4: An update after 6 or 38 shifted bits whose flag is wrong for that length, or after any count of shifted bits other than 6, 32 or 38, is discarded and counted in `err_count`. An update after exactly 32 bits (the read-out scan) is neither decoded nor counted. The counter saturates at its maximum.
- R5: While `sel` is low, the capture, shift and update strobes have no effect: no register, no counter and no `tdo` changes.
- R6: An accepted write to address 11 makes `job_start` high for exactly one core clock cycle. In that same cycle `job_words` shows all eleven words, with the word of address a at bits [(a-1)*32 +: 32].
- R7: An accepted write to address 0xD updates `clk_cfg` in the core domain and does not pulse `job_start`.
- R8: A read request for address 0xE removes the oldest queued result and returns it, in push order. When the queue is empty the read returns 0xFFFFFFFF and removes nothing.
- R9: The queue holds FIFO_DEPTH entries, 16 by default. A push while the queue is full is dropped, the entries already held are kept, and `res_overflow` goes high and stays high until reset.
- R10: After reset, `err_count`, `job_start`, `res_overflow` and `clk_cfg` are 0. Job registers read 0, and address 0xE reads 0xFFFFFFFF.
- R11: Writes to addresses 0, 12, 14 and 15 change nothing. In particular, a write to 0xE does not pop the queue. Reads of addresses 0, 12 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous active-low reset, TCK domain |
| sel | input | 1 | User instruction selected in the TAP |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| err_count | output | ERR_W | Saturating count of rejected frames |
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, core domain |
| res_push | input | 1 | Push a result into the queue |
| res_data | input | 32 | Result word to push |
| res_overflow | output | 1 | Sticky flag: a push was dropped because the queue was full |
| job_start | output | 1 | One-cycle pulse when a new job is handed over |
| job_words | output | 352 | Eleven job words captured in the core domain |
| clk_cfg | output | 32 | Clock setting carried into the core domain |

## Verification
Two things can meet in the same cycle. The core may push a result while the TCK side pops one, and the queue may fill at the same time as its read pointer is still crossing domains. The bench fills the queue to capacity, pushes one entry more, and then drains it over JTAG. It expects the first sixteen values in order, the sticky overflow flag set, and all ones once the queue is empty. A job handover and a clock-setting transfer also run through separate crossings. The bench checks that a clock-setting write leaves the job pulse count unchanged, and that the job pulse carries a full, consistent set of words.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int HDR_LSB  = DATA_W;
  localparam int FLAG_BIT = DATA_W + ADDR_W;
  localparam int PAR_BIT  = FLAG_BIT + 1;
  localparam int FRAME_W  = PAR_BIT + 1;
  localparam int RD_REQ_W = ADDR_W + 2;

  localparam int JOB_FIRST = 1;
  localparam int JOB_LAST  = 11;
  localparam int JOB_WORDS = JOB_LAST - JOB_FIRST + 1;

  localparam logic [ADDR_W-1:0] ADDR_CLK = 4'hD;
  localparam logic [ADDR_W-1:0] ADDR_POP = 4'hE;
  localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2,
    FK_BAD   = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rb_toggle_sync.sv
module rb_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], tgl_in};
  end

  assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/rb_frame_shift.sv
module rb_frame_shift
  import rb_pkg::*;
(
  input  logic              tck,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  input  logic [DATA_W-1:0] load_data,
  output logic              tdo,
  output frame_kind_e       kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int CNT_W = $clog2(FRAME_W + 1) + 1;

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sr_en;

  assign sr_en = sel && (capture || shift);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (capture) begin
      sr_d               = '0;
      sr_d[DATA_W-1:0]   = load_data;
      cnt_d              = '0;
    end else if (shift) begin
      sr_d = {tdi, sr_q[FRAME_W-1:1]};
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (sr_en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // Both frame lengths leave the header in the same top bits.
  always_comb begin
    kind = FK_NONE;
    addr = sr_q[HDR_LSB +: ADDR_W];
    data = sr_q[DATA_W-1:0];
    if (sel && update) begin
      if (cnt_q == CNT_W'(FRAME_W))
        kind = (sr_q[FLAG_BIT] && (^sr_q)) ? FK_WRITE : FK_BAD;
      else if (cnt_q == CNT_W'(RD_REQ_W))
        kind = (!sr_q[FLAG_BIT] && (^sr_q[FRAME_W-1:HDR_LSB])) ? FK_READ : FK_BAD;
      else if (cnt_q == CNT_W'(DATA_W))
        kind = FK_NONE;
      else
        kind = FK_BAD;
    end
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/rb_async_fifo.sv
module rb_async_fifo #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  output logic             overflow,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PTR_W-1:0] wbin_d, rbin_d;
  logic [PTR_W-1:0] rg_sync [STAGES];
  logic [PTR_W-1:0] wg_sync [STAGES];
  logic             full, wr_en, rd_en, ovf_q;

  // write side
  assign full  = (wgray_q == {~rg_sync[STAGES-1][PTR_W-1:PTR_W-2],
                              rg_sync[STAGES-1][PTR_W-3:0]});
  assign wr_en = push && !full;
  assign wbin_d = wbin_q + 1'b1;

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_en) begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n)             ovf_q <= 1'b0;
    else if (push && full)   ovf_q <= 1'b1;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      for (int i = 0; i < STAGES; i++) rg_sync[i] <= '0;
    end else begin
      rg_sync[0] <= rgray_q;
      for (int i = 1; i < STAGES; i++) rg_sync[i] <= rg_sync[i-1];
    end
  end

  // read side
  assign empty  = (rgray_q == wg_sync[STAGES-1]);
  assign rd_en  = pop && !empty;
  assign rbin_d = rbin_q + 1'b1;
  assign rdata  = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_en) begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      for (int i = 0; i < STAGES; i++) wg_sync[i] <= '0;
    end else begin
      wg_sync[0] <= wgray_q;
      for (int i = 1; i < STAGES; i++) wg_sync[i] <= wg_sync[i-1];
    end
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/jtag_regbank.sv
module jtag_regbank
  import rb_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int ERR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        tck,
  input  logic                        trst_n,
  input  logic                        sel,
  input  logic                        capture,
  input  logic                        shift,
  input  logic                        update,
  input  logic                        tdi,
  output logic                        tdo,
  output logic [ERR_W-1:0]            err_count,
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_push,
  input  logic [31:0]                 res_data,
  output logic                        res_overflow,
  output logic                        job_start,
  output logic [JOB_WORDS*DATA_W-1:0] job_words,
  output logic [DATA_W-1:0]           clk_cfg
);
  logic t_rst_n, c_rst_n;

  rb_rst_sync #(.STAGES(SYNC_STAGES)) u_trst (.clk(tck), .arst_n(trst_n), .rst_n(t_rst_n));
  rb_rst_sync #(.STAGES(SYNC_STAGES)) u_crst (.clk(clk), .arst_n(rst_n),  .rst_n(c_rst_n));

  // ---------------- TCK domain ----------------
  frame_kind_e       f_kind;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;

  rb_frame_shift u_shift (
    .tck(tck), .rst_n(t_rst_n), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .load_data(rdata_q), .tdo(tdo),
    .kind(f_kind), .addr(f_addr), .data(f_data)
  );

  logic              wr_acc, rd_acc;
  assign wr_acc = (f_kind == FK_WRITE);
  assign rd_acc = (f_kind == FK_READ);

  logic [DATA_W-1:0] job_q [JOB_WORDS];

  for (genvar g = 0; g < JOB_WORDS; g++) begin : g_job
    logic word_en;
    assign word_en = wr_acc && (f_addr == ADDR_W'(JOB_FIRST + g));
    always_ff @(posedge tck or negedge t_rst_n) begin
      if (!t_rst_n)     job_q[g] <= '0;
      else if (word_en) job_q[g] <= f_data;
    end
  end

  logic [DATA_W-1:0] cfg_q;
  logic              cfg_en, job_go, job_tgl_q, cfg_tgl_q;
  assign cfg_en = wr_acc && (f_addr == ADDR_CLK);
  assign job_go = wr_acc && (f_addr == ADDR_W'(JOB_LAST));

  always_ff @(posedge tck or negedge t_rst_n) begin
    if (!t_rst_n) begin
      cfg_q     <= '0;
      cfg_tgl_q <= 1'b0;
    end else if (cfg_en) begin
      cfg_q     <= f_data;
      cfg_tgl_q <= ~cfg_tgl_q;
    end
  end

  always_ff @(posedge tck or negedge t_rst_n) begin
    if (!t_rst_n)    job_tgl_q <= 1'b0;
    else if (job_go) job_tgl_q <= ~job_tgl_q;
  end

  // result queue
  logic              q_pop, q_empty;
  logic [DATA_W-1:0] q_rdata;
  assign q_pop = rd_acc && (f_addr == ADDR_POP);

  rb_async_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_fifo (
    .wclk(clk), .wrst_n(c_rst_n), .push(res_push), .wdata(res_data), .overflow(res_overflow),
    .rclk(tck), .rrst_n(t_rst_n), .pop(q_pop), .rdata(q_rdata), .empty(q_empty)
  );

  // read word selection
  always_comb begin
    rdata_d = '0;
    if (f_addr >= ADDR_W'(JOB_FIRST) && f_addr <= ADDR_W'(JOB_LAST))
      rdata_d = job_q[f_addr - ADDR_W'(JOB_FIRST)];
    else if (f_addr == ADDR_CLK)
      rdata_d = cfg_q;
    else if (f_addr == ADDR_POP)
      rdata_d = q_empty ? EMPTY_WORD : q_rdata;
  end

  assign rdata_en = rd_acc;

  always_ff @(posedge tck or negedge t_rst_n) begin
    if (!t_rst_n)      rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  logic err_en;
  assign err_en = (f_kind == FK_BAD) && (err_count != '1);

  always_ff @(posedge tck or negedge t_rst_n) begin
    if (!t_rst_n)    err_count <= '0;
    else if (err_en) err_count <= err_count + 1'b1;
  end

  // ---------------- core domain ----------------
  logic job_pulse, cfg_pulse;

  rb_toggle_sync #(.STAGES(SYNC_STAGES)) u_job_sync (
    .clk(clk), .rst_n(c_rst_n), .tgl_in(job_tgl_q), .pulse(job_pulse));
  rb_toggle_sync #(.STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk(clk), .rst_n(c_rst_n), .tgl_in(cfg_tgl_q), .pulse(cfg_pulse));

  for (genvar g = 0; g < JOB_WORDS; g++) begin : g_xfer
    always_ff @(posedge clk or negedge c_rst_n) begin
      if (!c_rst_n)       job_words[g*DATA_W +: DATA_W] <= '0;
      else if (job_pulse) job_words[g*DATA_W +: DATA_W] <= job_q[g];
    end
  end

  always_ff @(posedge clk or negedge c_rst_n) begin
    if (!c_rst_n) job_start <= 1'b0;
    else          job_start <= job_pulse;
  end

  always_ff @(posedge clk or negedge c_rst_n) begin
    if (!c_rst_n)       clk_cfg <= '0;
    else if (cfg_pulse) clk_cfg <= cfg_q;
  end
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int ERR_W = 8
) (
  input logic             tck,
  input logic             trst_n,
  input logic             sel,
  input logic             tdo,
  input logic [ERR_W-1:0] err_count,
  input logic             clk,
  input logic             rst_n,
  input logic             job_start,
  input logic             res_overflow
);
  // R6
  job_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_overflow |=> res_overflow);

  // R3
  err_step_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(err_count) |-> (err_count == $past(err_count) + 1'b1));

  // R5
  idle_err_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(err_count));

  // R5
  idle_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(tdo));
endmodule

bind jtag_regbank rb_checker #(.ERR_W(ERR_W)) u_rb_checker (
  .tck(tck), .trst_n(trst_n), .sel(sel), .tdo(tdo), .err_count(err_count),
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .res_overflow(res_overflow)
);

// File: tb/jtag_regbank_test.sv
module jtag_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 3 * CLK_PERIOD;

  logic tck = 1'b0, clk = 1'b0;
  logic trst_n, rst_n, sel, capture, shift, update, tdi, tdo;
  logic [7:0]   err_count;
  logic         res_push, res_overflow, job_start;
  logic [31:0]  res_data, clk_cfg;
  logic [351:0] job_words;

  int checks = 0;
  int errors = 0;
  int js_count = 0;
  int js_double = 0;
  logic js_prev = 1'b0;
  logic [351:0] js_words = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_regbank uut (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .err_count(err_count),
    .clk(clk), .rst_n(rst_n), .res_push(res_push), .res_data(res_data),
    .res_overflow(res_overflow), .job_start(job_start), .job_words(job_words),
    .clk_cfg(clk_cfg)
  );

  always @(negedge clk) begin
    if (job_start) begin
      js_count++;
      js_words = job_words;
      if (js_prev) js_double++;
    end
    js_prev = job_start;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [63:0] bits, input int n, output logic [63:0] got);
    got = '0;
    @(negedge tck); capture = 1'b1; shift = 1'b0; update = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); capture = 1'b0; shift = 1'b1; tdi = bits[i]; got[i] = tdo;
    end
    @(negedge tck); capture = 1'b0; shift = 1'b0; tdi = 1'b0;
    @(negedge tck); update = 1'b1;
    @(negedge tck); update = 1'b0;
  endtask

  task automatic write_raw(input logic [3:0] a, input logic [31:0] d,
                           input logic flag, input logic flip);
    logic [36:0] body;
    logic [63:0] frame, dummy;
    body  = {flag, a, d};
    frame = {26'd0, (~^body) ^ flip, body};
    scan(frame, 38, dummy);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    write_raw(a, d, 1'b1, 1'b0);
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
    logic [63:0] req, got;
    req = {58'd0, ~^{1'b0, a}, 1'b0, a};
    scan(req, 6, got);
    scan(64'd0, 32, got);
    d = got[31:0];
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); res_push = 1'b1; res_data = d;
    @(negedge clk); res_push = 1'b0;
  endtask

  function automatic logic [31:0] word_val(input int a);
    return 32'h1357_0000 ^ (a * 32'h0101_0111);
  endfunction

  task automatic t_reset;
    logic [31:0] r;
    chk("R10 err_count", {24'd0, err_count}, 32'd0);
    chk("R10 job_start", {31'd0, job_start}, 32'd0);
    chk("R10 overflow", {31'd0, res_overflow}, 32'd0);
    chk("R10 clk_cfg", clk_cfg, 32'd0);
    read_reg(4'd1, r);  chk("R10 job reg", r, 32'd0);
    read_reg(4'hE, r);  chk("R10 R8 empty pop", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs;
    logic [31:0] r;
    for (int a = 1; a <= 10; a++) write_reg(4'(a), word_val(a));
    for (int a = 1; a <= 10; a++) begin
      read_reg(4'(a), r);
      chk("R1 R2 readback", r, word_val(a));
    end
    chk("R6 no early start", js_count, 32'd0);
  endtask

  task automatic t_job;
    write_reg(4'd11, word_val(11));
    repeat (12) @(negedge clk);
    chk("R6 one pulse", js_count, 32'd1);
    chk("R6 pulse width", js_double, 32'd0);
    for (int a = 1; a <= 11; a++)
      chk("R6 job word", js_words[(a-1)*32 +: 32], word_val(a));
  endtask

  task automatic t_clk;
    logic [31:0] r;
    write_reg(4'hD, 32'd400);
    repeat (12) @(negedge clk);
    chk("R7 clk_cfg", clk_cfg, 32'd400);
    chk("R7 no job pulse", js_count, 32'd1);
    read_reg(4'hD, r);
    chk("R7 readback", r, 32'd400);
  endtask

  task automatic t_parity;
    logic [31:0] r;
    write_raw(4'd2, 32'hDEAD_BEEF, 1'b1, 1'b1);
    read_reg(4'd2, r);
    chk("R3 bad parity ignored", r, word_val(2));
    chk("R3 err counted", {24'd0, err_count}, 32'd1);
  endtask

  task automatic t_length;
    logic [31:0] r;
    logic [63:0] got;
    scan(64'h3FF, 10, got);
    chk("R4 odd length counted", {24'd0, err_count}, 32'd2);
    scan(64'd0, 32, got);
    chk("R4 readout scan not counted", {24'd0, err_count}, 32'd2);
    write_raw(4'd3, 32'h0BAD_0BAD, 1'b0, 1'b0);
    chk("R4 write flag 0 counted", {24'd0, err_count}, 32'd3);
    read_reg(4'd3, r);
    chk("R4 reg unchanged", r, word_val(3));
    scan({58'd0, ~^{1'b1, 4'd3}, 1'b1, 4'd3}, 6, got);
    chk("R4 read flag 1 counted", {24'd0, err_count}, 32'd4);
  endtask

  task automatic t_sel;
    logic [31:0] r;
    sel = 1'b0;
    write_reg(4'd4, 32'hFACE_0000);
    write_raw(4'd4, 32'h1, 1'b1, 1'b1);
    sel = 1'b1;
    chk("R5 no count while deselected", {24'd0, err_count}, 32'd4);
    read_reg(4'd4, r);
    chk("R5 reg unchanged", r, word_val(4));
  endtask

  task automatic t_fifo;
    logic [31:0] r;
    push(32'hA000_0001); push(32'hA000_0002); push(32'hA000_0003);
    repeat (4) @(negedge tck);
    read_reg(4'hE, r); chk("R8 pop 1", r, 32'hA000_0001);
    read_reg(4'hE, r); chk("R8 pop 2", r, 32'hA000_0002);
    read_reg(4'hE, r); chk("R8 pop 3", r, 32'hA000_0003);
    read_reg(4'hE, r); chk("R8 empty", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_overflow;
    logic [31:0] r;
    for (int i = 0; i < 16; i++) push(32'hB000_0000 + i);
    chk("R9 no overflow at 16", {31'd0, res_overflow}, 32'd0);
    push(32'hBEEF_BEEF);
    @(negedge clk);
    chk("R9 overflow set", {31'd0, res_overflow}, 32'd1);
    repeat (4) @(negedge tck);
    for (int i = 0; i < 16; i++) begin
      read_reg(4'hE, r);
      chk("R9 kept entry", r, 32'hB000_0000 + i);
    end
    read_reg(4'hE, r);
    chk("R9 dropped entry absent", r, 32'hFFFF_FFFF);
    chk("R9 overflow sticky", {31'd0, res_overflow}, 32'd1);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    write_reg(4'd12, 32'h1111_2222);
    write_reg(4'd0, 32'h3333_4444);
    write_reg(4'd15, 32'h5555_6666);
    read_reg(4'd12, r); chk("R11 addr 12 reads 0", r, 32'd0);
    read_reg(4'd0, r);  chk("R11 addr 0 reads 0", r, 32'd0);
    read_reg(4'd15, r); chk("R11 addr 15 reads 0", r, 32'd0);
    push(32'hC0DE_0001);
    repeat (4) @(negedge tck);
    write_reg(4'hE, 32'h7777_8888);
    read_reg(4'hE, r); chk("R11 write to pop addr no pop", r, 32'hC0DE_0001);
    read_reg(4'd1, r); chk("R11 job reg intact", r, word_val(1));
    chk("R11 no job pulse", js_count, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    trst_n = 1'b0; rst_n = 1'b0;
    sel = 1'b1; capture = 1'b0; shift = 1'b0; update = 1'b0; tdi = 1'b0;
    res_push = 1'b0; res_data = '0;
    repeat (4) @(negedge tck);
    trst_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge tck);
    t_reset;
    t_regs;
    t_job;
    t_clk;
    t_parity;
    t_length;
    t_sel;
    t_fifo;
    t_overflow;
    t_unmapped;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule